// File: doc/BRIEF.md
# Single-Channel Level Trigger with Sample-Rate Divider

This block sits in front of a capture engine in a small logic analyser. It divides the system clock into a sample strobe at a software-chosen rate, watches one of eight input channels on each strobe, and raises a one-cycle trigger pulse once a programmed number of transitions into a chosen level have been seen and a further programmed number of strobes have passed. The capture engine samples on the strobe and starts storing when the pulse arrives, using the capture length presented with it.

Software writes five configuration registers through a simple write port. These set the divider, the channel and level to match, the event count, the post-event delay and the capture length. It then pulses `arm`. A `disarm` pulse abandons a run at any point. After the trigger fires, `done` stays high until the next arm.

Top module: `la_trigger_top`

## Requirements
- R1: With divider register (address 0) holding N, `sample_stb` is high for one clock in every N+1 clocks. With N = 0 it is high every clock.
- R2: Address 1 bits [2:0] choose the watched channel. Transitions on any other channel have no effect on the trigger.
- R3: Address 1 bit 3 chooses the level: 1 matches high, 0 matches low. An event is a strobe at which the channel equals the level while the value at the previous strobe did not. The previous value is taken as 0 after reset. A level held over many strobes counts once.
- R4: The trigger fires only after K events, where K is the event count register (address 2). A K of 0 behaves as 1.
- R5: With delay register (address 3) holding D, the pulse follows the strobe that carries the K-th event when D = 0. Otherwise it follows the D-th strobe after that event. The pulse appears in the clock after the firing strobe.
- R6: After reset the unit is idle: `trig_pulse`, `done` and `busy` are 0. `arm` from idle or fired clears the counters and sets `busy`. `arm` has no effect while a run is in progress.
- R7: `disarm` returns the unit to idle from any state within one clock. It clears `busy` and `done`, and it takes priority over `arm`.
- R8: `trig_pulse` is high for exactly one clock. `done` rises with it and stays high until the next `arm` or `disarm`, while `busy` falls.
- R9: When the trigger fires, `cap_len` takes the value of the capture-length register (address 4) and holds it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Configuration write strobe |
| reg_addr | input | 3 | Configuration register index |
| reg_wdata | input | 16 | Configuration write data |
| arm | input | 1 | Start a trigger run |
| disarm | input | 1 | Abandon the run, go idle |
| chan_in | input | 8 | Input channels |
| sample_stb | output | 1 | Sample-enable strobe |
| trig_pulse | output | 1 | One-cycle trigger pulse |
| done | output | 1 | Trigger has fired |
| busy | output | 1 | Run in progress (counting events or delay) |
| cap_len | output | 16 | Capture length latched at trigger |

## Verification
Channel waveforms are stepped one strobe at a time. A single rising event separates a working level match from a dead one. A level held high across several strobes, followed by further rises, separates edge-qualified counting from plain level counting and checks the event count. A falling pattern on the top channel with a count of zero checks the low polarity and the zero-as-one rule. Toggling unwatched channels shows the selection is honoured. A delayed run is checked strobe by strobe, so an early or late pulse stands apart. Disarming in mid-delay and after firing confirms the return to idle.

// File: rtl/la_trig_pkg.sv
package la_trig_pkg;
  localparam int CFG_W = 16;
  localparam int NCH   = 8;
  localparam int SEL_W = $clog2(NCH);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_DELAY = 2'd2,
    ST_FIRED = 2'd3
  } trig_state_t;

  localparam logic [2:0] A_DIV   = 3'd0;
  localparam logic [2:0] A_CTRL  = 3'd1;
  localparam logic [2:0] A_COUNT = 3'd2;
  localparam logic [2:0] A_DELAY = 3'd3;
  localparam logic [2:0] A_LEN   = 3'd4;

  // required number of events: a zero setting means one
  function automatic logic [CFG_W-1:0] need_events(input logic [CFG_W-1:0] k);
    return (k == '0) ? CFG_W'(1) : k;
  endfunction

  // true when a counter about to advance reaches its limit
  function automatic logic reach(input logic [CFG_W-1:0] cnt,
                                 input logic [CFG_W-1:0] lim);
    return ({1'b0, cnt} + 1'b1) >= {1'b0, lim};
  endfunction
endpackage

// File: rtl/la_cfg_regs.sv
module la_cfg_regs
  import la_trig_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [2:0]       addr,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] div_val,
  output logic [SEL_W-1:0] chan_sel,
  output logic             match_hi,
  output logic [CFG_W-1:0] ev_count,
  output logic [CFG_W-1:0] delay_val,
  output logic [CFG_W-1:0] len_val
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_val   <= '0;
      chan_sel  <= '0;
      match_hi  <= 1'b1;
      ev_count  <= '0;
      delay_val <= '0;
      len_val   <= '0;
    end else if (we) begin
      case (addr)
        A_DIV:   div_val   <= wdata;
        A_CTRL: begin
          chan_sel <= wdata[SEL_W-1:0];
          match_hi <= wdata[SEL_W];
        end
        A_COUNT: ev_count  <= wdata;
        A_DELAY: delay_val <= wdata;
        A_LEN:   len_val   <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/la_rate_div.sv
module la_rate_div
  import la_trig_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] div_val,
  output logic             stb
);
  logic [CFG_W-1:0] cnt;

  assign stb = (cnt >= div_val);

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (stb) cnt <= '0;
    else          cnt <= cnt + 1'b1;
  end

  // R1: a nonzero divider never gives back-to-back strobes
  p_stb_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> (!stb || div_val == '0));
endmodule

// File: rtl/la_trig_fsm.sv
module la_trig_fsm
  import la_trig_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic [NCH-1:0]   chan_in,
  input  logic [SEL_W-1:0] chan_sel,
  input  logic             match_hi,
  input  logic [CFG_W-1:0] ev_count,
  input  logic [CFG_W-1:0] delay_val,
  input  logic [CFG_W-1:0] len_val,
  input  logic             arm,
  input  logic             disarm,
  output logic             trig_pulse,
  output logic             done,
  output logic             busy,
  output logic [CFG_W-1:0] cap_len
);
  trig_state_t      state;
  logic             prev_lvl;
  logic             cur_lvl;
  logic             ev_hit;
  logic             last_ev;
  logic             fire_now;
  logic [CFG_W-1:0] ev_cnt;
  logic [CFG_W-1:0] dly_cnt;

  assign cur_lvl  = chan_in[chan_sel];
  assign ev_hit   = stb && (cur_lvl == match_hi) && (prev_lvl != match_hi);
  assign last_ev  = ev_hit && reach(ev_cnt, need_events(ev_count));
  assign fire_now = ((state == ST_ARMED) && last_ev && (delay_val == '0)) ||
                    ((state == ST_DELAY) && stb && reach(dly_cnt, delay_val));
  assign done     = (state == ST_FIRED);
  assign busy     = (state == ST_ARMED) || (state == ST_DELAY);

  always_ff @(posedge clk) begin
    if (!rst_n) prev_lvl <= 1'b0;
    else if (stb) prev_lvl <= cur_lvl;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      ev_cnt     <= '0;
      dly_cnt    <= '0;
      trig_pulse <= 1'b0;
      cap_len    <= '0;
    end else begin
      trig_pulse <= 1'b0;
      if (disarm) begin
        state <= ST_IDLE;
      end else if (arm && !busy) begin
        state   <= ST_ARMED;
        ev_cnt  <= '0;
        dly_cnt <= '0;
      end else if (fire_now) begin
        state      <= ST_FIRED;
        trig_pulse <= 1'b1;
        cap_len    <= len_val;
      end else if (state == ST_ARMED && ev_hit) begin
        if (last_ev) begin
          state   <= ST_DELAY;
          dly_cnt <= '0;
        end else begin
          ev_cnt <= ev_cnt + 1'b1;
        end
      end else if (state == ST_DELAY && stb) begin
        dly_cnt <= dly_cnt + 1'b1;
      end
    end
  end

  // R8: the pulse lasts one clock
  p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |=> !trig_pulse);
  // R8: pulse and done go together
  p_pulse_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> (done && !busy));
  // R7: disarm wins and idles the unit
  p_disarm_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    disarm |=> (!done && !busy && !trig_pulse));
  // R5: firing happens only on a sample strobe
  p_fire_on_stb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(stb));
  // R4: event counter stays below the requirement
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARMED) |-> (ev_cnt < need_events(ev_count)));
endmodule

// File: rtl/la_trigger_top.sv
module la_trigger_top
  import la_trig_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [CFG_W-1:0] reg_wdata,
  input  logic             arm,
  input  logic             disarm,
  input  logic [NCH-1:0]   chan_in,
  output logic             sample_stb,
  output logic             trig_pulse,
  output logic             done,
  output logic             busy,
  output logic [CFG_W-1:0] cap_len
);
  logic [CFG_W-1:0] div_val, ev_count, delay_val, len_val;
  logic [SEL_W-1:0] chan_sel;
  logic             match_hi;

  la_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .div_val(div_val), .chan_sel(chan_sel), .match_hi(match_hi),
    .ev_count(ev_count), .delay_val(delay_val), .len_val(len_val)
  );

  la_rate_div u_div (
    .clk(clk), .rst_n(rst_n), .div_val(div_val), .stb(sample_stb)
  );

  la_trig_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .stb(sample_stb), .chan_in(chan_in),
    .chan_sel(chan_sel), .match_hi(match_hi), .ev_count(ev_count),
    .delay_val(delay_val), .len_val(len_val), .arm(arm), .disarm(disarm),
    .trig_pulse(trig_pulse), .done(done), .busy(busy), .cap_len(cap_len)
  );
endmodule

// File: tb/la_trigger_top_test.sv
`timescale 1ns/1ps
module la_trigger_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic        arm = 1'b0;
  logic        disarm = 1'b0;
  logic [7:0]  chan_in = '0;
  logic        sample_stb, trig_pulse, done, busy;
  logic [15:0] cap_len;

  int n_checks = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  la_trigger_top uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .arm(arm), .disarm(disarm), .chan_in(chan_in),
    .sample_stb(sample_stb), .trig_pulse(trig_pulse), .done(done),
    .busy(busy), .cap_len(cap_len)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic pulse_arm();
    arm = 1'b1; @(negedge clk); arm = 1'b0;
  endtask

  task automatic pulse_disarm();
    disarm = 1'b1; @(negedge clk); disarm = 1'b0;
  endtask

  // present a channel value, let exactly one strobe consume it,
  // return at the negedge right after that strobe's edge
  task automatic step(input logic [7:0] v);
    chan_in = v;
    while (!sample_stb) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic setup(input logic [2:0] ch, input logic hi, input logic [15:0] k,
                       input logic [15:0] d);
    wr(3'd1, {12'd0, hi, ch});
    wr(3'd2, k);
    wr(3'd3, d);
  endtask

  task automatic t_reset();
    check("R6 reset pulse", trig_pulse, 0);
    check("R6 reset done", done, 0);
    check("R6 reset busy", busy, 0);
  endtask

  task automatic t_rate();
    int first, second, c;
    wr(3'd0, 16'd3);
    c = 0; first = -1; second = -1;
    repeat (20) begin
      @(negedge clk);
      c++;
      if (sample_stb) begin
        if (first < 0) first = c; else if (second < 0) second = c;
      end
    end
    check("R1 period div=3", second - first, 4);
    wr(3'd0, 16'd0);
    c = 0;
    repeat (5) begin @(negedge clk); if (sample_stb) c++; end
    check("R1 div=0 every clock", c, 5);
    wr(3'd0, 16'd2);
  endtask

  task automatic t_basic();
    setup(3'd2, 1'b1, 16'd1, 16'd0);
    wr(3'd4, 16'd1234);
    step(8'h00);
    pulse_arm();
    check("R6 busy after arm", busy, 1);
    step(8'h00);
    check("R5 no pulse before event", trig_pulse, 0);
    step(8'h04);
    check("R5 pulse on event strobe", trig_pulse, 1);
    check("R8 done with pulse", done, 1);
    check("R9 cap_len latched", cap_len, 1234);
    @(negedge clk);
    check("R8 pulse one cycle", trig_pulse, 0);
    check("R8 done held", done, 1);
    check("R8 busy low when fired", busy, 0);
  endtask

  task automatic t_count_hold();
    int early;
    setup(3'd0, 1'b1, 16'd3, 16'd0);
    step(8'h00);
    pulse_arm();
    check("R8 done cleared by arm", done, 0);
    early = 0;
    step(8'h01); early += trig_pulse;
    step(8'h01); early += trig_pulse;
    step(8'h01); early += trig_pulse;
    step(8'h00); early += trig_pulse;
    step(8'h01); early += trig_pulse;
    step(8'h00); early += trig_pulse;
    check("R3 held level counts once", early, 0);
    step(8'h01);
    check("R4 fires on third event", trig_pulse, 1);
  endtask

  task automatic t_low_zero();
    setup(3'd7, 1'b0, 16'd0, 16'd0);
    step(8'hFF);
    pulse_arm();
    step(8'hFF);
    check("R3 no pulse while high", trig_pulse, 0);
    step(8'h7F);
    check("R4 count zero as one, low match", trig_pulse, 1);
  endtask

  task automatic t_other_chan();
    int hits;
    setup(3'd5, 1'b1, 16'd1, 16'd0);
    step(8'h00);
    pulse_arm();
    hits = 0;
    for (int i = 0; i < 6; i++) begin
      step((i % 2) ? 8'hDF : 8'h00);
      hits += trig_pulse;
    end
    check("R2 other channels ignored pulse", hits, 0);
    check("R2 still busy", busy, 1);
    step(8'h20);
    check("R2 selected channel fires", trig_pulse, 1);
  endtask

  task automatic t_delay();
    setup(3'd1, 1'b1, 16'd2, 16'd2);
    wr(3'd4, 16'd77);
    step(8'h00);
    pulse_arm();
    step(8'h02);
    step(8'h00);
    pulse_arm();
    check("R6 arm ignored while busy", busy, 1);
    step(8'h02);
    check("R5 no pulse at last event", trig_pulse, 0);
    step(8'h02);
    check("R5 no pulse at first delay strobe", trig_pulse, 0);
    step(8'h00);
    check("R5 pulse at second delay strobe", trig_pulse, 1);
    check("R9 cap_len new value", cap_len, 77);
  endtask

  task automatic t_disarm();
    int hits;
    setup(3'd3, 1'b1, 16'd1, 16'd3);
    step(8'h00);
    pulse_arm();
    step(8'h08);
    pulse_disarm();
    check("R7 disarm clears busy", busy, 0);
    hits = 0;
    for (int i = 0; i < 5; i++) begin step(8'h00); hits += trig_pulse; end
    check("R7 no pulse after disarm", hits, 0);
    check("R7 done low after disarm", done, 0);
    setup(3'd3, 1'b1, 16'd1, 16'd0);
    pulse_arm();
    step(8'h08);
    check("R7 fired again", done, 1);
    disarm = 1'b1; arm = 1'b1; @(negedge clk); disarm = 1'b0; arm = 1'b0;
    check("R7 disarm over arm busy", busy, 0);
    check("R7 disarm clears done", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rate();
    t_basic();
    t_count_hold();
    t_low_zero();
    t_other_chan();
    t_delay();
    t_disarm();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule